// File: doc/BRIEF.md
# Multi-Link Event Fragment Merger

This block collects event fragments arriving on eight front-end links and turns them into a single event stream. Each link delivers decoded 16-bit words with a valid strobe and start-of-fragment and end-of-fragment markers. Every link has its own fragment queue. When the trigger side announces an event number, the merger waits until every live link holds a complete fragment. It checks each fragment's event number against the announced one, then emits a header, the packed fragments of the agreeing links and a trailer.

A link whose fragment carries the wrong event number is left out of that event only, and its fragment is discarded. A link that fails to produce a fragment within a programmable number of cycles is declared dropped and stays out until reset. Neither case stops the run. A busy output tells the front ends to pause while a live link's queue holds its full quota of complete fragments.

Top module: `event_merger`

## Requirements
- R1: A link word is stored only when its valid strobe is high and it either carries the start marker or follows a start marker whose fragment has not yet seen its end marker. All other words, including an end marker outside a fragment, are discarded.
- R2: `busy` is high exactly while some non-dropped link queue holds MAX_EVT (default 5) complete fragments. It is low when every such queue holds MAX_EVT-1 or fewer.
- R3: A one-cycle `trig_valid` pulse while the merger is idle captures `trig_evnum` as the reference. It starts the building of one event, which yields exactly one header, the packed data and one trailer.
- R4: The header word is the first output word of an event: bits [31:24] = 0xE1, [23:16] = 0, [15:8] = reference event number, [7:0] = mask of included links (bit i = link i).
- R5: Fragments of included links follow in ascending link order. Word pairs are packed with the earlier word in bits [15:0] and the later one in [31:16]. An odd final word is padded with zeros in [31:16]. Packing starts afresh for every link.
- R6: The trailer word is the last word of an event and the only word with `out_last` high: bits [31:24] = 0xE2, [23:16] = 0, [15:8] = dropped-link mask, [7:0] = event-number-mismatch mask.
- R7: The event number of a fragment is bits [7:0] of its first word. On a mismatch, the link is cleared in the header mask, its fragment is read out and thrown away, and its bit is set in the trailer mismatch mask. The link takes part in the next event normally.
- R8: When a non-dropped link still has no complete fragment after `cfg_timeout`+1 cycles of waiting, it becomes dropped. A dropped link stays dropped until reset, is never read and is excluded from all later headers. The remaining links are merged as usual.
- R9: A dropped link's queue has no effect on `busy`.
- R10: After reset, `busy`, `out_valid` and `out_last` are low and no link is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_valid | input | 8 | Per-link word valid |
| lnk_sof | input | 8 | Per-link start-of-fragment marker |
| lnk_eof | input | 8 | Per-link end-of-fragment marker |
| lnk_data | input | 128 | Per-link 16-bit word, link i in bits [16i+15:16i] |
| trig_valid | input | 1 | Trigger event announcement strobe |
| trig_evnum | input | 8 | Announced event number |
| cfg_timeout | input | 16 | Wait limit in cycles before a missing link is dropped |
| busy | output | 1 | Ask front ends to pause |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Merged event word |
| out_last | output | 1 | Marks the trailer word |

## Verification
The bench drives fragment lengths of one word and of odd and even sizes. A packer that forgot the zero padding or carried a half word into the next link would emit shifted or merged words. It places a mismatched event number on the first, a middle and the last link. A merger that halted, kept the link in the mask or left its fragment in the queue would corrupt this event or the next. It queues four and then five fragments per link to find the exact `busy` threshold. It also withholds one link until the timeout fires, then checks that the drop persists and that the dead link's filling queue never raises `busy`. Stray words and end markers outside a fragment are injected to show they never reach the stream.

// File: rtl/event_merger_pkg.sv
package event_merger_pkg;

  localparam logic [7:0] HDR_TAG = 8'hE1;
  localparam logic [7:0] TRL_TAG = 8'hE2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_LINK,
    ST_TRL
  } mrg_state_e;

  function automatic logic [31:0] mk_header(logic [7:0] evnum, logic [7:0] incl);
    return {HDR_TAG, 8'h00, evnum, incl};
  endfunction

  function automatic logic [31:0] mk_trailer(logic [7:0] dropped, logic [7:0] mism);
    return {TRL_TAG, 8'h00, dropped, mism};
  endfunction

  function automatic logic [31:0] pack_pair(logic [15:0] later, logic [15:0] earlier);
    return {later, earlier};
  endfunction

endpackage

// File: rtl/event_merger_link_fifo.sv
module event_merger_link_fifo #(
  parameter int W       = 16,
  parameter int DEPTH   = 64,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [W-1:0]  in_data,
  input  logic          rd_en,
  output logic [W-1:0]  head_data,
  output logic          head_eof,
  output logic          empty,
  output logic [CW-1:0] frag_cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [W:0]  mem [DEPTH];
  logic [AW:0] wp, rp;
  logic        in_frag;
  logic        full, accept, frag_in, frag_out;

  assign empty    = (wp == rp);
  assign full     = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign accept   = in_valid && (in_sof || in_frag) && !full;
  assign frag_in  = accept && in_eof;
  assign frag_out = rd_en && !empty && head_eof;

  assign head_data = mem[rp[AW-1:0]][W-1:0];
  assign head_eof  = mem[rp[AW-1:0]][W];

  always_ff @(posedge clk) begin
    if (accept) mem[wp[AW-1:0]] <= {in_eof, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      in_frag  <= 1'b0;
      frag_cnt <= '0;
    end else begin
      if (accept) begin
        wp      <= wp + 1'b1;
        in_frag <= !in_eof;
      end
      if (rd_en && !empty) rp <= rp + 1'b1;
      frag_cnt <= frag_cnt + CW'(frag_in) - CW'(frag_out);
    end
  end

endmodule

// File: rtl/event_merger_builder.sv
module event_merger_builder
  import event_merger_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int CW = 7,
  parameter int TW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  input  logic [7:0]            trig_evnum,
  input  logic [TW-1:0]         cfg_timeout,
  input  logic [N-1:0][W-1:0]   head_data,
  input  logic [N-1:0]          head_eof,
  input  logic [N-1:0][CW-1:0]  frag_cnt,
  output logic [N-1:0]          rd_en,
  output logic [N-1:0]          drop_mask,
  output logic                  hdr_now,
  output logic                  out_valid,
  output logic [2*W-1:0]        out_data,
  output logic                  out_last
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  mrg_state_e     st;
  logic [7:0]     ref_q;
  logic [TW-1:0]  tmr;
  logic [N-1:0]   bad_q, has_frag, mism;
  logic [IW-1:0]  cur;
  logic           half;
  logic [W-1:0]   lo_q, cur_word;
  logic           cur_eof, last_link, all_ready;

  function automatic logic [7:0] to8(logic [N-1:0] v);
    logic [7:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      has_frag[i] = (frag_cnt[i] != '0);
      mism[i]     = !drop_mask[i] && (head_data[i][7:0] != ref_q);
    end
  end

  assign all_ready = &(has_frag | drop_mask);
  assign cur_word  = head_data[cur];
  assign cur_eof   = head_eof[cur];
  assign last_link = (cur == IW'(N-1));
  assign hdr_now   = (st == ST_HDR);

  always_comb begin
    rd_en = '0;
    if (st == ST_LINK && !drop_mask[cur]) rd_en[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ref_q     <= '0;
      tmr       <= '0;
      bad_q     <= '0;
      drop_mask <= '0;
      cur       <= '0;
      half      <= 1'b0;
      lo_q      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (st)
        ST_IDLE: if (trig_valid) begin
          ref_q <= trig_evnum;
          tmr   <= '0;
          st    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (all_ready) begin
            bad_q <= mism;
            st    <= ST_HDR;
          end else if (tmr == cfg_timeout) begin
            drop_mask <= drop_mask | ~has_frag;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_HDR: begin
          out_valid <= 1'b1;
          out_data  <= mk_header(ref_q, to8(~drop_mask & ~bad_q));
          cur       <= '0;
          half      <= 1'b0;
          st        <= ST_LINK;
        end
        ST_LINK: begin
          if (drop_mask[cur] || cur_eof) begin
            half <= 1'b0;
            if (last_link) st <= ST_TRL;
            else           cur <= cur + 1'b1;
          end
          if (!drop_mask[cur] && !bad_q[cur]) begin
            if (!half && !cur_eof) begin
              lo_q <= cur_word;
              half <= 1'b1;
            end else begin
              out_valid <= 1'b1;
              out_data  <= half ? pack_pair(cur_word, lo_q) : pack_pair('0, cur_word);
              if (!cur_eof) half <= 1'b0;
            end
          end
        end
        ST_TRL: begin
          out_valid <= 1'b1;
          out_last  <= 1'b1;
          out_data  <= mk_trailer(to8(drop_mask), to8(bad_q));
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/event_merger.sv
module event_merger #(
  parameter int N_LINKS = 8,
  parameter int W       = 16,
  parameter int DEPTH   = 64,
  parameter int MAX_EVT = 5,
  parameter int TW      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINKS-1:0]   lnk_valid,
  input  logic [N_LINKS-1:0]   lnk_sof,
  input  logic [N_LINKS-1:0]   lnk_eof,
  input  logic [N_LINKS*W-1:0] lnk_data,
  input  logic                 trig_valid,
  input  logic [7:0]           trig_evnum,
  input  logic [TW-1:0]        cfg_timeout,
  output logic                 busy,
  output logic                 out_valid,
  output logic [2*W-1:0]       out_data,
  output logic                 out_last
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [N_LINKS-1:0][W-1:0]  head_data;
  logic [N_LINKS-1:0]         head_eof, fifo_empty, rd_en, drop_mask, at_quota;
  logic [N_LINKS-1:0][CW-1:0] frag_cnt;
  logic                       hdr_now;

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    event_merger_link_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (lnk_valid[g]),
      .in_sof   (lnk_sof[g]),
      .in_eof   (lnk_eof[g]),
      .in_data  (lnk_data[g*W +: W]),
      .rd_en    (rd_en[g]),
      .head_data(head_data[g]),
      .head_eof (head_eof[g]),
      .empty    (fifo_empty[g]),
      .frag_cnt (frag_cnt[g])
    );
    assign at_quota[g] = (frag_cnt[g] >= CW'(MAX_EVT));
  end

  assign busy = |(at_quota & ~drop_mask);

  event_merger_builder #(.N(N_LINKS), .W(W), .CW(CW), .TW(TW)) u_build (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_evnum (trig_evnum),
    .cfg_timeout(cfg_timeout),
    .head_data  (head_data),
    .head_eof   (head_eof),
    .frag_cnt   (frag_cnt),
    .rd_en      (rd_en),
    .drop_mask  (drop_mask),
    .hdr_now    (hdr_now),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last)
  );

endmodule

// File: rtl/event_merger_chk.sv
module event_merger_chk
  import event_merger_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 7,
  parameter int MAX_EVT = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 out_valid,
  input logic [31:0]          out_data,
  input logic                 out_last,
  input logic                 hdr_now,
  input logic [N-1:0]         rd_en,
  input logic [N-1:0]         fifo_empty,
  input logic [N-1:0]         drop_mask,
  input logic [N-1:0][CW-1:0] frag_cnt
);

  a_r6_last_is_trailer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data[31:24] == TRL_TAG));

  a_r4_header_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_now |=> (out_valid && !out_last && out_data[31:24] == HDR_TAG));

  a_r8_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drop_mask & $past(drop_mask)) == $past(drop_mask)));

  a_r5_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));

  a_r5_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & fifo_empty) == '0);

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r2_busy_at_quota: assert property (@(posedge clk) disable iff (!rst_n)
      (!drop_mask[g] && frag_cnt[g] >= CW'(MAX_EVT)) |-> busy);
  end

endmodule

bind event_merger event_merger_chk #(.N(N_LINKS), .CW(CW), .MAX_EVT(MAX_EVT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .hdr_now   (hdr_now),
  .rd_en     (rd_en),
  .fifo_empty(fifo_empty),
  .drop_mask (drop_mask),
  .frag_cnt  (frag_cnt)
);

// File: tb/event_merger_tb.sv
`timescale 1ns/1ps
module event_merger_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   lnk_valid = '0, lnk_sof = '0, lnk_eof = '0;
  logic [127:0] lnk_data = '0;
  logic         trig_valid = 1'b0;
  logic [7:0]   trig_evnum = '0;
  logic [15:0]  cfg_timeout = 16'd200;
  logic         busy, out_valid, out_last;
  logic [31:0]  out_data;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  logic [31:0] got [$];
  logic [31:0] exp_q [$];

  always #4 clk = ~clk;

  event_merger u_dut (
    .clk(clk), .rst_n(rst_n), .lnk_valid(lnk_valid), .lnk_sof(lnk_sof),
    .lnk_eof(lnk_eof), .lnk_data(lnk_data), .trig_valid(trig_valid),
    .trig_evnum(trig_evnum), .cfg_timeout(cfg_timeout), .busy(busy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      got.push_back(out_data);
      if (out_last) done_cnt++;
    end
  end

  // ev, base length, length step, mismatched link (15 = none), spare
  localparam logic [23:0] VEC [6] = '{
    {8'h11, 4'd1, 4'd0, 4'hF, 4'h0},
    {8'h22, 4'd2, 4'd1, 4'hF, 4'h0},
    {8'h33, 4'd4, 4'd3, 4'd5, 4'h0},
    {8'h44, 4'd3, 4'd2, 4'd0, 4'h0},
    {8'hFF, 4'd6, 4'd1, 4'd7, 4'h0},
    {8'h00, 4'd2, 4'd0, 4'hF, 4'h0}
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int flen(int base, int step, int i);
    return base + ((i * step) % 4);
  endfunction

  function automatic logic [15:0] wd(int i, int k, logic [7:0] ev0);
    if (k == 0) return {8'hA0 + 8'(i), ev0};
    return {4'h5, 4'(i), 8'(k)};
  endfunction

  task automatic send_event(logic [7:0] ev, int base, int step, int bad, logic [7:0] skip);
    int maxl = 0;
    for (int i = 0; i < 8; i++) if (flen(base, step, i) > maxl) maxl = flen(base, step, i);
    for (int c = 0; c < maxl; c++) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        int l = flen(base, step, i);
        if (!skip[i] && c < l) begin
          lnk_valid[i] = 1'b1;
          lnk_sof[i]   = (c == 0);
          lnk_eof[i]   = (c == l - 1);
          lnk_data[i*16 +: 16] = wd(i, c, (i == bad) ? (ev ^ 8'h80) : ev);
        end else begin
          lnk_valid[i] = 1'b0;
          lnk_sof[i]   = 1'b0;
          lnk_eof[i]   = 1'b0;
        end
      end
    end
    @(negedge clk);
    lnk_valid = '0; lnk_sof = '0; lnk_eof = '0;
  endtask

  task automatic build_exp(logic [7:0] ev, int base, int step, int bad, logic [7:0] dropm);
    logic [7:0] badm = '0;
    logic [7:0] incl;
    if (bad < 8) badm[bad] = 1'b1;
    incl = ~dropm & ~badm;
    exp_q.delete();
    exp_q.push_back({8'hE1, 8'h00, ev, incl});
    for (int i = 0; i < 8; i++) begin
      if (incl[i]) begin
        int l = flen(base, step, i);
        for (int k = 0; k < l; k += 2) begin
          logic [15:0] hi = (k + 1 < l) ? wd(i, k + 1, ev) : 16'h0000;
          exp_q.push_back({hi, wd(i, k, ev)});
        end
      end
    end
    exp_q.push_back({8'hE2, 8'h00, dropm, badm});
  endtask

  task automatic run_trig(logic [7:0] ev, output bit ok);
    int start = got.size();
    int dstart = done_cnt;
    int n;
    ok = 1'b1;
    @(negedge clk);
    trig_valid = 1'b1; trig_evnum = ev;
    @(negedge clk);
    trig_valid = 1'b0;
    for (int w = 0; w < 3000 && done_cnt == dstart; w++) @(negedge clk);
    n = got.size() - start;
    check(n == exp_q.size(), "R3 word count", 32'(n), 32'(exp_q.size()));
    if (n != exp_q.size()) ok = 1'b0;
    for (int j = 0; j < exp_q.size() && j < n; j++) begin
      string tag = (j == 0) ? "R4 header" : (j == exp_q.size() - 1) ? "R6 trailer" : "R5 data";
      check(got[start + j] == exp_q[j], tag, got[start + j], exp_q[j]);
      if (got[start + j] != exp_q[j]) ok = 1'b0;
    end
  endtask

  task automatic garbage(int link);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      lnk_valid[link] = 1'b1; lnk_sof[link] = 1'b0; lnk_eof[link] = 1'b1;
      lnk_data[link*16 +: 16] = 16'hDEAD;
    end
    @(negedge clk);
    lnk_valid = '0; lnk_eof = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tests, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!busy && !out_valid && !out_last, "R10 reset outputs",
          {29'd0, busy, out_valid, out_last}, 32'd0);

    // table of events: lengths, padding, mismatches (R5, R7)
    for (int v = 0; v < 6; v++) begin
      logic [7:0] ev   = VEC[v][23:16];
      int         base = int'(VEC[v][15:12]);
      int         step = int'(VEC[v][11:8]);
      int         bad  = int'(VEC[v][7:4]);
      send_event(ev, base, step, bad, 8'h00);
      build_exp(ev, base, step, bad, 8'h00);
      run_trig(ev, ok);
      if (bad < 8) check(ok, "R7 mismatched link excluded", 32'(ok), 32'd1);
    end

    // R1: stray words and end markers outside a fragment
    garbage(2);
    send_event(8'h55, 2, 1, 15, 8'h00);
    garbage(2);
    build_exp(8'h55, 2, 1, 15, 8'h00);
    run_trig(8'h55, ok);
    check(ok, "R1 stray words ignored (1)", 32'(ok), 32'd1);
    send_event(8'h56, 1, 1, 15, 8'h00);
    build_exp(8'h56, 1, 1, 15, 8'h00);
    run_trig(8'h56, ok);
    check(ok, "R1 stray words ignored (2)", 32'(ok), 32'd1);

    // R2: busy threshold
    for (int e = 0; e < 4; e++) send_event(8'h60 + 8'(e), 2, 0, 15, 8'h00);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy low at four", 32'(busy), 32'd0);
    send_event(8'h64, 2, 0, 15, 8'h00);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy high at five", 32'(busy), 32'd1);
    for (int e = 0; e < 5; e++) begin
      build_exp(8'h60 + 8'(e), 2, 0, 15, 8'h00);
      run_trig(8'h60 + 8'(e), ok);
      if (e == 0) begin
        @(negedge clk);
        check(busy == 1'b0, "R2 busy released at four", 32'(busy), 32'd0);
      end
    end

    // R8: timeout drop of link 3
    cfg_timeout = 16'd20;
    send_event(8'h70, 3, 1, 15, 8'h08);
    build_exp(8'h70, 3, 1, 15, 8'h08);
    run_trig(8'h70, ok);
    check(ok, "R8 link dropped on timeout", 32'(ok), 32'd1);

    // R9: dropped link queue never raises busy
    for (int e = 0; e < 5; e++) send_event(8'h90, 1, 0, 15, 8'hF7);
    @(negedge clk);
    check(busy == 1'b0, "R9 dropped link ignored by busy", 32'(busy), 32'd0);

    // R8: drop is sticky even with data waiting on link 3
    send_event(8'h71, 2, 1, 15, 8'h08);
    build_exp(8'h71, 2, 1, 15, 8'h08);
    run_trig(8'h71, ok);
    check(ok, "R8 drop persists", 32'(ok), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule